// File: doc/BRIEF.md
# ACPI Embedded Controller Port Responder

This block is the controller side of the two-port ACPI embedded controller interface. The host writes bytes either to a command port or to a data port. It reads a data byte and a status byte back. Each host write is latched into an input holding register, together with a flag that says whether the byte went to the command port. A state machine then consumes the byte and runs one of three command flows: a memory read, a memory write or an event query. Any byte the controller produces is placed in an output holding register, and the data-ready flag is raised.

The memory space is small and has four locations: a fixed revision byte, a test byte, a read-only test complement and a backlight level. An event query takes the lowest pending event from an external event source. It returns that event's 1-based number and pulses a one-hot clear back to the source. The two event-pending status bits are driven straight from the `sci_req` and `smi_req` inputs.

The states are Idle, Decode, ReadAddr, ReadOut, WriteAddr, WriteVal and Query. The transitions are:
- Idle→Decode when a command byte is consumed.
- Decode→ReadAddr, WriteAddr or Query for the three known opcodes. Decode→Idle for any other opcode.
- ReadAddr→ReadOut, and WriteAddr→WriteVal, when a data byte is consumed.
- ReadOut→Idle, WriteVal→Idle and Query→Idle.
- ReadAddr, WriteAddr or WriteVal→Decode when a command byte arrives instead of data.

Top module: `acpi_ec_port`

## Requirements
- R1: The status byte is laid out as follows. Bit 0 is output-full, bit 1 is input-full, bit 2 is processing (the machine is not in Idle) and bit 3 is last-write-was-command. Bit 5 follows `sci_req` and bit 6 follows `smi_req`. Bits 4 and 7 always read 0. After reset, with both request inputs low, the status byte reads 0x00.
- R2: A host write sets input-full and records the port (command or data) in the cycle after it is sampled. The machine clears input-full when it consumes the byte. From Idle, a command byte makes the processing bit rise two cycles after the write.
- R3: Read opcode 0x80. The machine consumes the opcode, waits for an address data byte and consumes it. One cycle later it places the addressed byte on `host_rdata` and sets output-full.
- R4: A host read of the data port (`host_rd`) clears output-full in the next cycle.
- R5: Write opcode 0x81. The machine consumes the opcode, then an address byte, then a value byte. It stores the value when the value byte is consumed.
- R6: Address 0x02 reads as 0xFF minus the byte last written to address 0x01. The test byte resets to 0x00. Writes to 0x02 leave its value unchanged.
- R7: Address 0x00 reads 0x01.
- R8: Address 0x03 holds the backlight level and drives the `backlight` port. A written value above 100 is stored as 100. The level resets to 0.
- R9: Query opcode 0x84. The machine returns the 1-based index of the lowest set bit of `evt_pend`, or 0x00 if no bit is set. In the cycle where output-full rises, `evt_clr` carries a one-hot pulse for that bit, or zero if no bit was set.
- R10: Any other opcode holds the processing bit for exactly one cycle and does not set output-full.
- R11: Addresses outside 0x00 to 0x03 read as 0x00. Writes to them change no location.
- R12: A command byte that arrives while the machine waits for an address or a value abandons the current flow and starts the new command. A data byte that arrives in Idle is consumed and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_wr_cmd | input | 1 | Set when the write goes to the command port |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | One-cycle strobe: host reads the data port |
| host_rdata | output | 8 | Output holding register |
| status | output | 8 | Status byte |
| sci_req | input | 1 | SCI event pending, reflected in status bit 5 |
| smi_req | input | 1 | SMI event pending, reflected in status bit 6 |
| evt_pend | input | NUM_EVT | Pending events from the event source, bit i is event i+1 |
| evt_clr | output | NUM_EVT | One-hot clear pulse for the event returned by a query |
| backlight | output | 8 | Current backlight level |

## Verification
The bench checks the following corner cases:
- The complement location after writes to both the test byte and the complement address. A design that decodes the write address loosely would corrupt the test byte.
- The level clamp with 200. A design without the clamp would show 200 on `backlight`.
- An unknown opcode, counting processing cycles. A design that stalls would count more than one; one that loads a byte would raise output-full.
- Queries with no event, with two events and after the source clears the returned bit. A priority encoder that picks the wrong end would return 8 instead of 6.
- A command that interrupts a read waiting for its address. A design that treats it as an address would return a memory byte instead of a query result.
- A stray data byte in Idle. It must not start any flow.

// File: rtl/acpi_ec_pkg.sv
package acpi_ec_pkg;

    localparam logic [7:0] OP_MEM_READ  = 8'h80;
    localparam logic [7:0] OP_MEM_WRITE = 8'h81;
    localparam logic [7:0] OP_EVT_QUERY = 8'h84;

    localparam logic [7:0] SPACE_REV = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RD_ADDR,
        ST_RD_OUT,
        ST_WR_ADDR,
        ST_WR_VAL,
        ST_QUERY
    } ec_state_t;

    typedef struct packed {
        logic rsvd;
        logic smi;
        logic sci;
        logic burst;
        logic last_cmd;
        logic proc;
        logic in_full;
        logic out_full;
    } ec_status_t;

endpackage

// File: rtl/acpi_ec_hostregs.sv
module acpi_ec_hostregs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_wr_cmd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              take_in,
    input  logic              load_out,
    input  logic [DATA_W-1:0] load_val,
    output logic              in_full,
    output logic              out_full,
    output logic              last_cmd,
    output logic [DATA_W-1:0] in_byte,
    output logic [DATA_W-1:0] out_byte
);

    // Input side: a new host write wins over consumption in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_full  <= 1'b0;
            last_cmd <= 1'b0;
            in_byte  <= '0;
        end else if (host_wr) begin
            in_full  <= 1'b1;
            last_cmd <= host_wr_cmd;
            in_byte  <= host_wdata;
        end else if (take_in) begin
            in_full  <= 1'b0;
        end
    end

    // Output side: a fresh load wins over a host read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full <= 1'b0;
            out_byte <= '0;
        end else if (load_out) begin
            out_full <= 1'b1;
            out_byte <= load_val;
        end else if (host_rd) begin
            out_full <= 1'b0;
        end
    end

endmodule

// File: rtl/acpi_ec_space.sv
module acpi_ec_space #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int LVL_MAX = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] level
);

    localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TEST  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TCOMP = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(3);
    localparam logic [DATA_W-1:0] LVL_TOP = DATA_W'(LVL_MAX);

    logic [DATA_W-1:0] test_q;
    logic [DATA_W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q  <= '0;
            level_q <= '0;
        end else if (wr_en) begin
            if (addr == A_TEST) begin
                test_q <= wr_data;
            end
            if (addr == A_LEVEL) begin
                level_q <= (wr_data > LVL_TOP) ? LVL_TOP : wr_data;
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_REV:   rd_data = DATA_W'(acpi_ec_pkg::SPACE_REV);
            A_TEST:  rd_data = test_q;
            A_TCOMP: rd_data = ~test_q;
            A_LEVEL: rd_data = level_q;
            default: rd_data = '0;
        endcase
    end

    assign level = level_q;

endmodule

// File: rtl/acpi_ec_evt_pick.sv
module acpi_ec_evt_pick #(
    parameter int NUM_EVT = 32,
    parameter int CODE_W  = 8
) (
    input  logic [NUM_EVT-1:0] pend,
    output logic [CODE_W-1:0]  code,
    output logic [NUM_EVT-1:0] hot
);

    logic [NUM_EVT:0] below;

    assign below[0] = 1'b0;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_pick
        assign below[i+1] = below[i] | pend[i];
        assign hot[i]     = pend[i] & ~below[i];
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (hot[i]) begin
                code = CODE_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/acpi_ec_port.sv
module acpi_ec_port #(
    parameter int NUM_EVT = 32,
    parameter int LVL_MAX = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_wr_cmd,
    input  logic [7:0]         host_wdata,
    input  logic               host_rd,
    output logic [7:0]         host_rdata,
    output logic [7:0]         status,
    input  logic               sci_req,
    input  logic               smi_req,
    input  logic [NUM_EVT-1:0] evt_pend,
    output logic [NUM_EVT-1:0] evt_clr,
    output logic [7:0]         backlight
);
    import acpi_ec_pkg::*;

    localparam int BYTE_W = 8;

    ec_state_t state, nxt;

    logic              in_full, out_full, last_cmd;
    logic [BYTE_W-1:0] in_byte, out_byte;
    logic              take_in, load_out, mem_we, cmd_ld, addr_ld, clr_now;
    logic [BYTE_W-1:0] load_val;
    logic [BYTE_W-1:0] cmd_q, addr_q;
    logic [BYTE_W-1:0] space_rd;
    logic [BYTE_W-1:0] evt_code;
    logic [NUM_EVT-1:0] evt_hot;
    ec_status_t        stat_s;

    acpi_ec_hostregs #(.DATA_W(BYTE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_wr_cmd (host_wr_cmd),
        .host_wdata  (host_wdata),
        .host_rd     (host_rd),
        .take_in     (take_in),
        .load_out    (load_out),
        .load_val    (load_val),
        .in_full     (in_full),
        .out_full    (out_full),
        .last_cmd    (last_cmd),
        .in_byte     (in_byte),
        .out_byte    (out_byte)
    );

    acpi_ec_space #(.ADDR_W(BYTE_W), .DATA_W(BYTE_W), .LVL_MAX(LVL_MAX)) u_space (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .addr    (addr_q),
        .wr_data (in_byte),
        .rd_data (space_rd),
        .level   (backlight)
    );

    acpi_ec_evt_pick #(.NUM_EVT(NUM_EVT), .CODE_W(BYTE_W)) u_pick (
        .pend (evt_pend),
        .code (evt_code),
        .hot  (evt_hot)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and control outputs
    always_comb begin
        nxt      = state;
        take_in  = 1'b0;
        load_out = 1'b0;
        load_val = '0;
        mem_we   = 1'b0;
        cmd_ld   = 1'b0;
        addr_ld  = 1'b0;
        clr_now  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_full) begin
                    take_in = 1'b1;
                    if (last_cmd) begin
                        cmd_ld = 1'b1;
                        nxt    = ST_DECODE;
                    end
                end
            end
            ST_DECODE: begin
                case (cmd_q)
                    OP_MEM_READ:  nxt = ST_RD_ADDR;
                    OP_MEM_WRITE: nxt = ST_WR_ADDR;
                    OP_EVT_QUERY: nxt = ST_QUERY;
                    default:      nxt = ST_IDLE;
                endcase
            end
            ST_RD_ADDR, ST_WR_ADDR: begin
                if (in_full) begin
                    take_in = 1'b1;
                    if (last_cmd) begin
                        cmd_ld = 1'b1;
                        nxt    = ST_DECODE;
                    end else begin
                        addr_ld = 1'b1;
                        nxt     = (state == ST_RD_ADDR) ? ST_RD_OUT : ST_WR_VAL;
                    end
                end
            end
            ST_RD_OUT: begin
                load_out = 1'b1;
                load_val = space_rd;
                nxt      = ST_IDLE;
            end
            ST_WR_VAL: begin
                if (in_full) begin
                    take_in = 1'b1;
                    if (last_cmd) begin
                        cmd_ld = 1'b1;
                        nxt    = ST_DECODE;
                    end else begin
                        mem_we = 1'b1;
                        nxt    = ST_IDLE;
                    end
                end
            end
            ST_QUERY: begin
                load_out = 1'b1;
                load_val = evt_code;
                clr_now  = 1'b1;
                nxt      = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Command, address and event-clear registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            evt_clr <= '0;
        end else begin
            if (cmd_ld) begin
                cmd_q <= in_byte;
            end
            if (addr_ld) begin
                addr_q <= in_byte;
            end
            evt_clr <= clr_now ? evt_hot : '0;
        end
    end

    always_comb begin
        stat_s.rsvd     = 1'b0;
        stat_s.smi      = smi_req;
        stat_s.sci      = sci_req;
        stat_s.burst    = 1'b0;
        stat_s.last_cmd = last_cmd;
        stat_s.proc     = (state != ST_IDLE);
        stat_s.in_full  = in_full;
        stat_s.out_full = out_full;
    end

    assign status     = stat_s;
    assign host_rdata = out_byte;

endmodule

// File: rtl/acpi_ec_port_chk.sv
module acpi_ec_port_chk #(
    parameter int NUM_EVT = 32,
    parameter int LVL_MAX = 100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic               host_wr_cmd,
    input logic               host_rd,
    input logic [7:0]         status,
    input logic [NUM_EVT-1:0] evt_pend,
    input logic [NUM_EVT-1:0] evt_clr,
    input logic [7:0]         backlight
);

    AST_RSVD_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] == 1'b0) && (status[4] == 1'b0)); // R1

    AST_WRITE_FILLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> status[1]); // R2

    AST_CMD_STARTS_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wr_cmd && !status[1] && !status[2]) |=> ##1 status[2]); // R2

    AST_OUT_AFTER_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(status[2])); // R3

    AST_READ_DRAINS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !status[2]) |=> !status[0]); // R4

    AST_LEVEL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        backlight <= 8'(LVL_MAX)); // R8

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_clr)); // R9

    AST_CLR_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_clr) |-> ((evt_clr & $past(evt_pend)) == evt_clr)); // R9

endmodule

bind acpi_ec_port acpi_ec_port_chk #(.NUM_EVT(NUM_EVT), .LVL_MAX(LVL_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_wr_cmd (host_wr_cmd),
    .host_rd     (host_rd),
    .status      (status),
    .evt_pend    (evt_pend),
    .evt_clr     (evt_clr),
    .backlight   (backlight)
);

// File: tb/acpi_ec_port_test.sv
module acpi_ec_port_test;
    localparam int NEVT = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            host_wr = 1'b0;
    logic            host_wr_cmd = 1'b0;
    logic [7:0]      host_wdata = 8'h00;
    logic            host_rd = 1'b0;
    logic            sci_req = 1'b0;
    logic            smi_req = 1'b0;
    logic [NEVT-1:0] evt_pend = '0;
    logic [7:0]      host_rdata;
    logic [7:0]      status;
    logic [NEVT-1:0] evt_clr;
    logic [7:0]      backlight;

    int errors = 0;
    int checks = 0;

    acpi_ec_port #(.NUM_EVT(NEVT), .LVL_MAX(100)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_wr_cmd (host_wr_cmd),
        .host_wdata  (host_wdata),
        .host_rd     (host_rd),
        .host_rdata  (host_rdata),
        .status      (status),
        .sci_req     (sci_req),
        .smi_req     (smi_req),
        .evt_pend    (evt_pend),
        .evt_clr     (evt_clr),
        .backlight   (backlight)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int              m_step, m_op, m_where, m_held, m_held_cmd, m_in_full, m_out_full, m_out;
    int              m_test, m_level;
    logic [NEVT-1:0] m_clr;

    function automatic int space_peek(input int a);
        if (a == 0) return 1;
        if (a == 1) return m_test;
        if (a == 2) return 255 - m_test;
        if (a == 3) return m_level;
        return 0;
    endfunction

    always @(posedge clk) begin
        int took, give, give_val, next_step;
        logic [NEVT-1:0] next_clr;
        took = 0; give = 0; give_val = 0; next_step = m_step; next_clr = '0;
        if (!rst_n) begin
            m_step = 0; m_op = 0; m_where = 0; m_held = 0; m_held_cmd = 0;
            m_in_full = 0; m_out_full = 0; m_out = 0; m_test = 0; m_level = 0; m_clr = '0;
        end else begin
            if (m_step == 1) begin
                if (m_op == 8'h80) next_step = 2;
                else if (m_op == 8'h81) next_step = 4;
                else if (m_op == 8'h84) next_step = 6;
                else next_step = 0;
            end else if (m_step == 3) begin
                give = 1; give_val = space_peek(m_where); next_step = 0;
            end else if (m_step == 6) begin
                give = 1;
                for (int i = NEVT - 1; i >= 0; i--) begin
                    if (evt_pend[i]) begin
                        give_val = i + 1;
                        next_clr = '0;
                        next_clr[i] = 1'b1;
                    end
                end
                next_step = 0;
            end else if (m_in_full != 0) begin
                took = 1;
                if (m_held_cmd != 0) begin
                    m_op = m_held; next_step = 1;
                end else if (m_step == 2) begin
                    m_where = m_held; next_step = 3;
                end else if (m_step == 4) begin
                    m_where = m_held; next_step = 5;
                end else if (m_step == 5) begin
                    if (m_where == 1) m_test = m_held;
                    if (m_where == 3) m_level = (m_held > 100) ? 100 : m_held;
                    next_step = 0;
                end
            end
            if (host_wr) begin
                m_in_full = 1; m_held = host_wdata; m_held_cmd = host_wr_cmd;
            end else if (took != 0) begin
                m_in_full = 0;
            end
            if (give != 0) begin
                m_out_full = 1; m_out = give_val;
            end else if (host_rd) begin
                m_out_full = 0;
            end
            m_clr  = next_clr;
            m_step = next_step;
        end
    end

    // Compare every cycle, one unit after the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check("R1", "status bit 0", status[0], m_out_full);
            check("R2", "status bit 1", status[1], m_in_full);
            check("R1", "status bit 2", status[2], m_step != 0);
            check("R2", "status bit 3", status[3], m_held_cmd);
            check("R1", "status bit 5", status[5], sci_req);
            check("R1", "status bit 6", status[6], smi_req);
            check("R1", "status bits 4,7", {status[7], status[4]}, 0);
            check("R3", "host_rdata", host_rdata, m_out);
            check("R8", "backlight", backlight, m_level);
            check("R9", "evt_clr", evt_clr, m_clr);
        end
    end

    // ---------------- host-side tasks ----------------
    task automatic host_put(input logic is_cmd, input logic [7:0] b);
        @(negedge clk);
        host_wr = 1'b1; host_wr_cmd = is_cmd; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
        forever begin
            @(negedge clk); #1;
            if (!status[1]) break;
        end
    endtask

    task automatic host_take(output logic [7:0] v, output logic [NEVT-1:0] c);
        forever begin
            @(negedge clk); #1;
            if (status[0]) break;
        end
        v = host_rdata;
        c = evt_clr;
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        #1;
        check("R4", "output-full after host read", status[0], 0);
    endtask

    task automatic space_read(input logic [7:0] a, output logic [7:0] v);
        logic [NEVT-1:0] c;
        host_put(1'b1, 8'h80);
        host_put(1'b0, a);
        host_take(v, c);
    endtask

    task automatic space_write(input logic [7:0] a, input logic [7:0] val);
        host_put(1'b1, 8'h81);
        host_put(1'b0, a);
        host_put(1'b0, val);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_query(output logic [7:0] v, output logic [NEVT-1:0] c);
        host_put(1'b1, 8'h84);
        host_take(v, c);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=hung expected=completed");
        finish_run();
    end

    initial begin
        logic [7:0]      v;
        logic [NEVT-1:0] c;
        int              busy_cycles;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", "status after reset", status, 8'h00);
        check("R8", "backlight after reset", backlight, 0);

        // R7 and R3: revision byte via the read flow
        space_read(8'h00, v);
        check("R7", "revision byte", v, 8'h01);

        // R6: complement of reset test byte
        space_read(8'h02, v);
        check("R6", "complement at reset", v, 8'hFF);

        // R5 / R6: write test byte and read both locations
        space_write(8'h01, 8'h35);
        space_read(8'h01, v);
        check("R5", "test byte written", v, 8'h35);
        space_read(8'h02, v);
        check("R6", "complement of 0x35", v, 8'hCA);

        // R6: writes to the complement address are ignored
        space_write(8'h02, 8'h00);
        space_read(8'h02, v);
        check("R6", "complement after write to it", v, 8'hCA);
        space_read(8'h01, v);
        check("R6", "test byte after complement write", v, 8'h35);

        // R8: level store and clamp
        space_write(8'h03, 8'd60);
        check("R8", "backlight port after 60", backlight, 60);
        space_read(8'h03, v);
        check("R8", "level readback", v, 60);
        space_write(8'h03, 8'd200);
        check("R8", "backlight clamp", backlight, 100);

        // R11: out-of-range address
        space_write(8'h10, 8'h77);
        space_read(8'h10, v);
        check("R11", "out-of-range read", v, 8'h00);
        space_read(8'h01, v);
        check("R11", "test byte untouched", v, 8'h35);
        check("R11", "level untouched", backlight, 100);

        // R9: queries
        run_query(v, c);
        check("R9", "query with nothing pending", v, 0);
        check("R9", "clear with nothing pending", c, 0);
        evt_pend = 32'h0000_00A0;
        run_query(v, c);
        check("R9", "query lowest of 0xA0", v, 6);
        check("R9", "clear for 0xA0", c, 32'h0000_0020);
        evt_pend = evt_pend & ~c;
        run_query(v, c);
        check("R9", "query after clear", v, 8);
        check("R9", "second clear", c, 32'h0000_0080);
        evt_pend = evt_pend & ~c;

        // R10: unknown opcode
        @(negedge clk);
        host_wr = 1'b1; host_wr_cmd = 1'b1; host_wdata = 8'h55;
        @(negedge clk);
        host_wr = 1'b0;
        busy_cycles = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            if (status[2]) busy_cycles++;
            check("R10", "no output for unknown opcode", status[0], 0);
        end
        check("R10", "processing cycles for unknown opcode", busy_cycles, 1);

        // R12: command interrupts a read waiting for its address
        evt_pend = 32'h0000_0008;
        host_put(1'b1, 8'h80);
        host_put(1'b1, 8'h84);
        host_take(v, c);
        check("R12", "aborted read runs query", v, 4);
        evt_pend = '0;

        // R12 / R2: data byte in idle is discarded
        host_put(1'b0, 8'h42);
        repeat (3) @(negedge clk);
        #1;
        check("R2", "last write flagged as data", status[3], 0);
        check("R12", "stray data starts nothing", status[2], 0);
        check("R12", "stray data gives no output", status[0], 0);

        // R1: event-pending inputs
        @(negedge clk);
        sci_req = 1'b1;
        #1;
        check("R1", "sci bit", status[5], 1);
        @(negedge clk);
        sci_req = 1'b0; smi_req = 1'b1;
        #1;
        check("R1", "smi bit", status[6], 1);
        check("R1", "sci bit low", status[5], 0);
        @(negedge clk);
        smi_req = 1'b0;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule